// File: doc/BRIEF.md
# Receive Character Queue with Per-Character Error Tags

This block is the receive-side character store of a serial channel. An external receiver shifter delivers each assembled byte together with three error indications (break seen, bad stop bit, bad parity). The block keeps every byte in a small first-in first-out queue with its three indications beside it. When the queue is full, one further byte waits in a holding stage. Software-facing logic reads bytes from the head of the queue and reads one 8-bit status word.

Errors are reported in one of two ways. In per-character mode, the status word shows the tags of the byte at the head of the queue, and those tags leave with the byte when it is read. In accumulating mode, the status word shows the OR of the tags of every byte received since the last clear, and reading bytes does not change it. A single sticky overrun flag records that a byte arrived while the queue was full. Two command strobes act on the stored state: one clears the error state, the other resets the receive side. The transmitter's empty and ready indications are passed through into the status word.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the queue is empty. Status bits 7:4, 1 and 0 read zero.
- R2: Bytes are read out in arrival order. `rd_data` shows the head byte, and a read pulse with `rd_en` removes it.
- R3: Status bit 0 (ready) is 1 whenever the queue holds at least one byte. Status bit 1 (full) is 1 exactly when all DEPTH (default 3) entries are occupied.
- R4: With `blk_mode`=0, status bits 7:5 are the break, framing and parity tags of the head byte, in that order from bit 7 down. They read 000 when the queue is empty.
- R5: With `blk_mode`=0, reading a byte discards its tags, and status bits 7:5 then show the tags of the next byte.
- R6: With `blk_mode`=1, status bits 7:5 are the OR of the tags of every byte received since the last error clear or receive reset. Reading bytes does not clear them.
- R7: A byte that arrives while the queue is full and no read is taking place goes into the holding stage, replacing any byte already held. The queue contents are unchanged, status bit 4 (overrun) is set, and the held byte enters the queue at the next read.
- R8: Overrun is a single sticky channel flag. It stays set until an error clear or a receive reset.
- R9: An `err_reset` pulse clears the overrun flag, the accumulated tags and the tags of every stored byte. It does not remove any byte.
- R10: An `rx_reset` pulse empties the queue, discards the held byte and clears every error bit. It takes priority over a byte arriving in the same cycle.
- R11: Status bit 3 equals `tx_empty` and status bit 2 equals `tx_ready` in the same cycle.
- R12: A read pulse while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | A byte is delivered by the shifter this cycle |
| wr_data | input | DATA_W | Delivered byte |
| wr_brk | input | 1 | Break tag of the delivered byte |
| wr_fe | input | 1 | Framing-error tag of the delivered byte |
| wr_pe | input | 1 | Parity-error tag of the delivered byte |
| rd_en | input | 1 | Read (pop) the head byte |
| rd_data | output | DATA_W | Head byte of the queue |
| err_reset | input | 1 | Error-clear command strobe |
| rx_reset | input | 1 | Receive-side reset command strobe |
| blk_mode | input | 1 | 0 = per-character tags, 1 = accumulated tags |
| tx_empty | input | 1 | Transmitter empty indication |
| tx_ready | input | 1 | Transmitter ready indication |
| status | output | 8 | {brk, fe, pe, overrun, tx_empty, tx_ready, full, ready} |

## Verification
The bench fills the queue and then pushes one more byte. A design that let the extra byte overwrite a stored entry, or that dropped the held byte instead of moving it in at the next read, would return the wrong data order. After that, the bench reads the queue past the overflow and checks that the overrun flag has not cleared itself. It issues an error clear while tagged bytes are still stored; a design that cleared only the overrun flag would still show stale tags at the head. In accumulating mode, the bench reads every byte and checks that the OR of the tags survives, which catches a design that drives bits 7:5 from the head entry.

// File: rtl/rxq_pkg.sv
// Package rxq_pkg: types shared by the receive character queue.
// Assumes the three error tags always travel together with a byte.
package rxq_pkg;
    // Per-character error tag, ordered as it appears in status bits 7:5
    typedef struct packed {
        logic brk;
        logic fe;
        logic pe;
    } rxq_tag_t;

    localparam int unsigned STAT_W = 8;
endpackage

// File: rtl/rxq_store.sv
// Module rxq_store: circular queue of DEPTH bytes, each with its own tag.
// One holding stage behind it catches a byte that arrives while the queue
// is full. A held byte moves into the queue at the next pop. Assumes the
// holding stage is only occupied while the queue is full.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              clr_tags,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  rxq_tag_t          push_tag,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output rxq_tag_t          head_tag,
    output logic              full,
    output logic              nonempty,
    output logic              ovf
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem_d [DEPTH];
    rxq_tag_t          mem_t [DEPTH];
    logic [PW-1:0]     rd_ptr, wr_ptr;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] hold_d;
    rxq_tag_t          hold_t;
    logic              hold_v;

    logic              do_pop, take_hold, direct, wr_fifo, to_hold;
    logic [DATA_W-1:0] wr_d;
    rxq_tag_t          wr_t;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Decide where an arriving byte goes and whether the held byte moves in
    always_comb begin
        full      = (cnt == CW'(DEPTH));
        nonempty  = (cnt != '0);
        do_pop    = pop && nonempty;
        take_hold = do_pop && hold_v;
        direct    = push && !hold_v && (!full || do_pop);
        wr_fifo   = take_hold || direct;
        to_hold   = push && !direct;
        ovf       = to_hold;
        wr_d      = take_hold ? hold_d : push_data;
        wr_t      = take_hold ? (clr_tags ? '0 : hold_t) : push_tag;
    end

    // Pointers, occupancy count and holding-stage valid flag
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
            hold_v <= 1'b0;
        end else begin
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (wr_fifo) wr_ptr <= bump(wr_ptr);
            case ({wr_fifo, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            hold_v <= to_hold || (hold_v && !take_hold);
        end
    end

    // Entry storage: write the incoming byte, clear tags on command
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem_d[i] <= '0;
                mem_t[i] <= '0;
            end
            hold_d <= '0;
            hold_t <= '0;
        end else begin
            if (clr_tags) begin
                for (int i = 0; i < int'(DEPTH); i++) mem_t[i] <= '0;
            end
            if (wr_fifo) begin
                mem_d[wr_ptr] <= wr_d;
                mem_t[wr_ptr] <= wr_t;
            end
            if (to_hold) begin
                hold_d <= push_data;
                hold_t <= push_tag;
            end else if (clr_tags) begin
                hold_t <= '0;
            end
        end
    end

    // Head of queue is presented without a read latency
    always_comb begin
        head_data = mem_d[rd_ptr];
        head_tag  = mem_t[rd_ptr];
    end
endmodule

// File: rtl/rxq_flags.sv
// Module rxq_flags: channel-level error state, i.e. the OR of the tags of
// every byte received since the last clear, and the sticky overrun flag.
// Assumes an overflow in the same cycle as a clear leaves overrun set.
module rxq_flags
    import rxq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flush,
    input  logic     clr,
    input  logic     push,
    input  rxq_tag_t push_tag,
    input  logic     ovf,
    output rxq_tag_t acc_tag,
    output logic     overrun
);
    // Accumulate arriving tags and hold overrun until cleared
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            acc_tag <= '0;
            overrun <= 1'b0;
        end else begin
            acc_tag <= (clr ? rxq_tag_t'('0) : acc_tag) | (push ? push_tag : rxq_tag_t'('0));
            overrun <= (overrun && !clr) || ovf;
        end
    end
endmodule

// File: rtl/rxq_status.sv
// Module rxq_status: assembles the 8-bit status word from queue state,
// channel flags and the transmitter indications. Purely combinational.
module rxq_status
    import rxq_pkg::*;
(
    input  logic              blk_mode,
    input  logic              nonempty,
    input  logic              full,
    input  rxq_tag_t          head_tag,
    input  rxq_tag_t          acc_tag,
    input  logic              overrun,
    input  logic              tx_empty,
    input  logic              tx_ready,
    output logic [STAT_W-1:0] status
);
    rxq_tag_t shown;

    // Select the tag source for bits 7:5 and pack the word
    always_comb begin
        if (blk_mode)      shown = acc_tag;
        else if (nonempty) shown = head_tag;
        else               shown = '0;
        status = {shown, overrun, tx_empty, tx_ready, full, nonempty};
    end
endmodule

// File: rtl/rx_err_fifo.sv
// Module rx_err_fifo: receive character queue with per-byte error tags,
// a holding stage for overflow, and two ways of reporting errors.
// rx_reset takes priority over every other input in the same cycle.
module rx_err_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_brk,
    input  logic              wr_fe,
    input  logic              wr_pe,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              err_reset,
    input  logic              rx_reset,
    input  logic              blk_mode,
    input  logic              tx_empty,
    input  logic              tx_ready,
    output logic [7:0]        status
);
    rxq_tag_t in_tag, head_tag, acc_tag;
    logic     full, nonempty, ovf, overrun;

    // Bundle the incoming tags in status-bit order
    always_comb in_tag = '{brk: wr_brk, fe: wr_fe, pe: wr_pe};

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_reset),
        .clr_tags  (err_reset),
        .push      (wr_en),
        .push_data (wr_data),
        .push_tag  (in_tag),
        .pop       (rd_en),
        .head_data (rd_data),
        .head_tag  (head_tag),
        .full      (full),
        .nonempty  (nonempty),
        .ovf       (ovf)
    );

    rxq_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (rx_reset),
        .clr      (err_reset),
        .push     (wr_en),
        .push_tag (in_tag),
        .ovf      (ovf),
        .acc_tag  (acc_tag),
        .overrun  (overrun)
    );

    rxq_status u_status (
        .blk_mode (blk_mode),
        .nonempty (nonempty),
        .full     (full),
        .head_tag (head_tag),
        .acc_tag  (acc_tag),
        .overrun  (overrun),
        .tx_empty (tx_empty),
        .tx_ready (tx_ready),
        .status   (status)
    );
endmodule

// File: rtl/rx_err_fifo_chk.sv
// Module rx_err_fifo_chk: port-level temporal properties of rx_err_fifo,
// attached by the bind statement at the end of this file.
module rx_err_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       err_reset,
    input logic       rx_reset,
    input logic       blk_mode,
    input logic [7:0] status
);
    // R3: a full queue is never reported as empty
    p_full_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> status[0]);

    // R7: a byte arriving into a full queue with no read sets overrun
    p_full_push_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && wr_en && !rd_en && !rx_reset) |=> status[4]);

    // R8: overrun stays set unless a clear or receive reset is issued
    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && !err_reset && !rx_reset) |=> status[4]);

    // R9: an error clear with no overflow in the same cycle drops overrun
    p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_reset && !wr_en && !rx_reset) |=> !status[4]);

    // R6: accumulated break tag survives reads while in block mode
    p_block_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && status[7] && !err_reset && !rx_reset) |=> (!blk_mode || status[7]));

    // R10: receive reset leaves queue empty and all error bits clear
    p_rx_reset_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> ((status & 8'hF3) == 8'h00));

    // R12: a read on an empty queue with no arrival keeps it empty
    p_empty_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[0] && rd_en && !wr_en) |=> !status[0]);
endmodule

bind rx_err_fifo rx_err_fifo_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .err_reset (err_reset),
    .rx_reset  (rx_reset),
    .blk_mode  (blk_mode),
    .status    (status)
);

// File: tb/test_rx_err_fifo.sv
// Bench for rx_err_fifo: driver tasks feed a reference queue, a negedge
// monitor pops it whenever a read is presented and compares the outputs.
module test_rx_err_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_brk = 1'b0, wr_fe = 1'b0, wr_pe = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0, err_reset = 1'b0, rx_reset = 1'b0, blk_mode = 1'b0;
    logic       tx_empty = 1'b1, tx_ready = 1'b0;
    logic [7:0] rd_data, status;

    int total = 0;
    int bad   = 0;

    // Reference model: {tags[2:0], data[7:0]}
    logic [10:0] exp_q[$];
    logic [10:0] m_hold;
    bit          m_hold_v = 0;
    logic [2:0]  m_acc = '0;
    bit          m_ovr = 0;

    rx_err_fifo #(.DATA_W(8), .DEPTH(DEPTH)) i_rx_err_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_brk(wr_brk), .wr_fe(wr_fe), .wr_pe(wr_pe), .rd_en(rd_en),
        .rd_data(rd_data), .err_reset(err_reset), .rx_reset(rx_reset),
        .blk_mode(blk_mode), .tx_empty(tx_empty), .tx_ready(tx_ready),
        .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        logic [2:0] f;
        if (blk_mode)               f = m_acc;
        else if (exp_q.size() != 0) f = exp_q[0][10:8];
        else                        f = 3'b000;
        return {f, m_ovr, tx_empty, tx_ready, exp_q.size() == DEPTH, exp_q.size() != 0};
    endfunction

    task automatic check_stat(input string req);
        @(negedge clk);
        chk(status == exp_status(), req, {8'h00, status}, {8'h00, exp_status()});
    endtask

    // Driver: deliver one byte and update the reference model
    task automatic send(input logic [7:0] d, input logic [2:0] f);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = d; {wr_brk, wr_fe, wr_pe} = f;
        @(posedge clk); #1;
        wr_en = 1'b0; {wr_brk, wr_fe, wr_pe} = 3'b000;
        m_acc |= f;
        if (exp_q.size() < DEPTH) exp_q.push_back({f, d});
        else begin
            m_hold = {f, d}; m_hold_v = 1; m_ovr = 1;
        end
    endtask

    // Driver: one read pulse; the monitor compares before the edge
    task automatic read_one();
        @(posedge clk); #1;
        rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
        if (m_hold_v) begin
            exp_q.push_back(m_hold);
            m_hold_v = 0;
        end
    endtask

    task automatic pulse_err_reset();
        @(posedge clk); #1;
        err_reset = 1'b1;
        @(posedge clk); #1;
        err_reset = 1'b0;
        m_acc = '0; m_ovr = 0;
        foreach (exp_q[i]) exp_q[i][10:8] = 3'b000;
        m_hold[10:8] = 3'b000;
    endtask

    task automatic pulse_rx_reset();
        @(posedge clk); #1;
        rx_reset = 1'b1;
        @(posedge clk); #1;
        rx_reset = 1'b0;
        exp_q.delete(); m_hold_v = 0; m_acc = '0; m_ovr = 0;
    endtask

    // Monitor: compare the head byte and its tags against the model
    always @(negedge clk) begin
        if (rst_n && rd_en && exp_q.size() > 0) begin
            logic [10:0] e;
            e = exp_q.pop_front();
            chk(rd_data == e[7:0], "R2 read order", {8'h00, rd_data}, {8'h00, e[7:0]});
            if (!blk_mode)
                chk(status[7:5] == e[10:8], "R5 per-char tags", {13'h0, status[7:5]}, {13'h0, e[10:8]});
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_stat("R1 reset state");

        // R11: transmitter indications pass straight through
        #1 tx_empty = 1'b0; tx_ready = 1'b1;
        check_stat("R11 tx bits");

        // R12: read on empty queue is ignored
        read_one();
        check_stat("R12 empty read");

        // R3 R4 R5: per-character tags on three bytes
        send(8'hA5, 3'b100);
        check_stat("R4 head tag");
        send(8'h3C, 3'b010);
        send(8'h7E, 3'b001);
        check_stat("R3 full");
        read_one();
        check_stat("R5 next tag");
        read_one();
        read_one();
        check_stat("R4 empty tags zero");

        // R7 R8: overflow into the holding stage
        send(8'h11, 3'b000);
        send(8'h22, 3'b000);
        send(8'h33, 3'b000);
        send(8'h44, 3'b001);
        check_stat("R7 overrun set");
        read_one();
        check_stat("R7 held byte moved in");
        read_one();
        read_one();
        read_one();
        check_stat("R8 overrun sticky");
        pulse_err_reset();
        check_stat("R9 overrun cleared");

        // R9: clear drops stored tags but keeps the byte
        send(8'h55, 3'b010);
        check_stat("R4 tag before clear");
        pulse_err_reset();
        check_stat("R9 tags cleared");
        read_one();

        // R6: accumulation in block mode
        #1 blk_mode = 1'b1;
        send(8'h01, 3'b001);
        send(8'h02, 3'b100);
        check_stat("R6 accumulated");
        read_one();
        read_one();
        check_stat("R6 kept after reads");
        pulse_err_reset();
        check_stat("R9 accumulation cleared");

        // R10: receive reset with a full queue and a held byte
        send(8'h61, 3'b010);
        send(8'h62, 3'b000);
        send(8'h63, 3'b000);
        send(8'h64, 3'b100);
        check_stat("R7 overrun block mode");
        pulse_rx_reset();
        check_stat("R10 reset empties");
        #1 blk_mode = 1'b0;
        send(8'h9A, 3'b000);
        check_stat("R10 one byte after reset");
        read_one();
        check_stat("R10 empty again");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule